// File: doc/BRIEF.md
# Phase-Shift Full-Bridge PWM Channel with Sync Chaining

This block is one gate-drive channel for a phase-shifted full-bridge power stage. A count-up time base runs from zero to a programmable period and then wraps. An action stage turns the counter into a raw square wave: high from the zero point and low at a compare point, so a compare of half the period gives 50% duty. A dead-band stage then makes a complementary pair of gate signals. Each pair has its own programmable rising-edge delay, so the two switches of a leg are never on at the same time.

Several channels are chained through their sync pins. A master channel has phase loading off and issues a one-cycle sync pulse each time its counter wraps to zero. A slave channel has phase loading on, so an incoming sync pulse forces its counter to a programmable phase value. The phase shift between the two bridge legs sets the power transfer. A channel can also relay its sync input straight to its sync output. This lets a later channel, such as the one that drives the synchronous rectifiers, stay aligned with the master. The counter value is brought out for observation.

Top module: `psfb_pwm_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `ctr_o` = 0, `gate_a_o` = 0, `gate_b_o` = 0 and `sync_o` = 0.
- R2: With no phase load, `ctr_o` steps up by one each cycle while it is below `period_i`. In the cycle after it equals `period_i`, it reads 0. Each period therefore lasts `period_i`+1 cycles.
- R3: A new `period_i` value takes effect at the next edge, with no shadowing. If the counter is at or above the new value, it wraps to 0 on that edge.
- R4: With both delays at zero, `gate_a_o` is high for exactly `cmp_i` cycles of every period. The raw wave is set when the counter is 0 and cleared when the counter equals `cmp_i`, where 1 ≤ `cmp_i` ≤ `period_i`.
- R5: Per period, `gate_a_o` is high for `cmp_i` − `red_i` cycles and `gate_b_o` is high for (`period_i`+1−`cmp_i`) − `fed_i` cycles. Each rising edge is delayed by its own delay value, and each falling edge follows the raw wave with no extra delay.
- R6: `gate_a_o` and `gate_b_o` are never high in the same cycle.
- R7: With `sync_sel_i` = 0 (own zero), `sync_o` is a one-cycle pulse that appears in exactly the cycle in which `ctr_o` has just wrapped to 0. It occurs once per period.
- R8: With `phase_en_i` = 1, a `sync_i` pulse at an edge loads `phase_i` into the counter, so `ctr_o` equals `phase_i` in the following cycle.
- R9: When a phase load coincides with a wrap, the load wins. `ctr_o` shows `phase_i` rather than 0, and no own-zero sync pulse is issued for that wrap.
- R10: With `phase_en_i` = 0, `sync_i` is ignored by the counter, which keeps stepping by one.
- R11: With `sync_sel_i` = 1 (pass-through), `sync_o` equals `sync_i` delayed by one cycle, and wraps of the channel's own counter produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| period_i | input | CW | Period value; the counter runs 0..period_i |
| cmp_i | input | CW | Compare value that clears the raw wave |
| phase_i | input | CW | Value loaded into the counter on a sync load |
| phase_en_i | input | 1 | 1 = slave: sync_i loads phase_i |
| sync_sel_i | input | 1 | Sync output source: 0 = own zero wrap, 1 = pass sync_i |
| sync_i | input | 1 | Sync pulse from the upstream channel |
| red_i | input | DW | Rising-edge delay for gate A, in clocks |
| fed_i | input | DW | Rising-edge delay for gate B, in clocks |
| ctr_o | output | CW | Time-base counter value |
| sync_o | output | 1 | Sync pulse to the downstream channel |
| gate_a_o | output | 1 | Gate A: raw wave with delayed rise |
| gate_b_o | output | 1 | Gate B: inverted raw wave with delayed rise |

## Verification
The checks assume a period of at least one. A period of zero would make the own-zero sync pulse hold high, and R7 would not hold. The duty checks also assume each delay is no larger than the high time of its lane. The stimulus keeps every period at 5 or more, keeps the compare value inside the period, and keeps each delay no longer than its lane's high time. Sync pulses are driven for a single cycle, and the configuration only changes between measurement windows.

// File: rtl/psfb_pwm_pkg.sv
// Shared types for the phase-shift PWM channel.
package psfb_pwm_pkg;
    // Source of the sync output pulse.
    typedef enum logic {
        SYNC_FROM_ZERO  = 1'b0,
        SYNC_FROM_INPUT = 1'b1
    } sync_src_e;

    // Lane indices of the dead-band stage.
    localparam int LANE_A   = 0;
    localparam int LANE_B   = 1;
    localparam int N_LANES  = 2;
endpackage

// File: rtl/pwm_timebase.sv
// Count-up time base with phase load and sync output selection.
// Assumes period_i >= 1 when the own-zero sync source is used.
// A phase load has priority over a wrap.
module pwm_timebase
    import psfb_pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] phase_i,
    input  logic          phase_en_i,
    input  logic          sync_i,
    input  sync_src_e     sync_src_i,
    output logic [CW-1:0] ctr_o,
    output logic          sync_o
);
    logic load;
    logic wrap;

    // Decide between a phase load and a wrap for this cycle.
    always_comb begin
        load = phase_en_i & sync_i;
        wrap = !load && (ctr_o >= period_i);
    end

    // Advance the counter and register the selected sync source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctr_o  <= '0;
            sync_o <= 1'b0;
        end else begin
            if (load)
                ctr_o <= phase_i;
            else if (wrap)
                ctr_o <= '0;
            else
                ctr_o <= ctr_o + CW'(1);
            sync_o <= (sync_src_i == SYNC_FROM_INPUT) ? sync_i : wrap;
        end
    end
endmodule

// File: rtl/pwm_action.sv
// Action stage: sets the raw wave at counter zero and clears it at compare.
// The set at zero takes priority if compare is also zero.
module pwm_action #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] ctr_i,
    input  logic [CW-1:0] cmp_i,
    output logic          raw_o
);
    // Register the set/clear decision for the raw wave.
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_o <= 1'b0;
        else if (ctr_i == '0)
            raw_o <= 1'b1;
        else if (ctr_i == cmp_i)
            raw_o <= 1'b0;
    end
endmodule

// File: rtl/pwm_edge_delay.sv
// Delays the rising edge of its input by dly_i clocks; the falling edge
// follows the input one clock later, like the rise with zero delay.
// The run counter saturates, so long high times are safe.
module pwm_edge_delay #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_i,
    input  logic [DW-1:0] dly_i,
    output logic          out_o
);
    logic [DW-1:0] run;

    // Count how long the input has been high and release the output.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_i) begin
            run   <= '0;
            out_o <= 1'b0;
        end else begin
            out_o <= (run >= dly_i);
            if (run != '1)
                run <= run + DW'(1);
        end
    end
endmodule

// File: rtl/psfb_pwm_channel.sv
// One phase-shift full-bridge PWM channel: time base, action stage and
// a complementary dead-band pair. Sync can be chained across channels.
// Assumes a period of at least 1 and synchronous, single-clock inputs.
module psfb_pwm_channel
    import psfb_pwm_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] cmp_i,
    input  logic [CW-1:0] phase_i,
    input  logic          phase_en_i,
    input  logic          sync_sel_i,
    input  logic          sync_i,
    input  logic [DW-1:0] red_i,
    input  logic [DW-1:0] fed_i,
    output logic [CW-1:0] ctr_o,
    output logic          sync_o,
    output logic          gate_a_o,
    output logic          gate_b_o
);
    sync_src_e             sync_src;
    logic                  raw;
    logic [N_LANES-1:0]    lane_in;
    logic [N_LANES-1:0]    lane_out;
    logic [DW-1:0]         lane_dly [N_LANES];

    // Map the select pin and lane inputs onto the dead-band pair.
    always_comb begin
        sync_src          = sync_src_e'(sync_sel_i);
        lane_in[LANE_A]   = raw;
        lane_in[LANE_B]   = ~raw;
        lane_dly[LANE_A]  = red_i;
        lane_dly[LANE_B]  = fed_i;
    end

    pwm_timebase #(.CW(CW)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_i   (period_i),
        .phase_i    (phase_i),
        .phase_en_i (phase_en_i),
        .sync_i     (sync_i),
        .sync_src_i (sync_src),
        .ctr_o      (ctr_o),
        .sync_o     (sync_o)
    );

    pwm_action #(.CW(CW)) u_act (
        .clk   (clk),
        .rst_n (rst_n),
        .ctr_i (ctr_o),
        .cmp_i (cmp_i),
        .raw_o (raw)
    );

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        pwm_edge_delay #(.DW(DW)) u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .in_i  (lane_in[g]),
            .dly_i (lane_dly[g]),
            .out_o (lane_out[g])
        );
    end

    assign gate_a_o = lane_out[LANE_A];
    assign gate_b_o = lane_out[LANE_B];
endmodule

// File: rtl/psfb_pwm_channel_chk.sv
// Assertion checker for psfb_pwm_channel, attached by bind.
// Assumes period_i >= 1 whenever the own-zero sync source is selected.
module psfb_pwm_channel_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] period_i,
    input logic [CW-1:0] phase_i,
    input logic          phase_en_i,
    input logic          sync_sel_i,
    input logic          sync_i,
    input logic [CW-1:0] ctr_o,
    input logic          sync_o,
    input logic          gate_a_o,
    input logic          gate_b_o
);
    // R1: reset clears the observable state
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (ctr_o == '0 && !gate_a_o && !gate_b_o && !sync_o));

    // R2: step by one below the period
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_o < period_i && !(phase_en_i && sync_i)) |=> ctr_o == CW'($past(ctr_o) + 1));

    // R2: wrap to zero at the period
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_o >= period_i && !(phase_en_i && sync_i)) |=> ctr_o == '0);

    // R8: phase load, R9: load wins over wrap
    p_phase_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_en_i && sync_i) |=> ctr_o == $past(phase_i));

    // R6: gates never both high
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_a_o && gate_b_o));

    // R7: own-zero pulse only on a freshly wrapped zero count
    p_zero_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_sel_i && !$past(sync_sel_i) && sync_o) |-> ctr_o == '0);

    // R11: pass-through copies sync_i one cycle later
    p_pass_through_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sel_i |=> sync_o == $past(sync_i));
endmodule

bind psfb_pwm_channel psfb_pwm_channel_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_i   (period_i),
    .phase_i    (phase_i),
    .phase_en_i (phase_en_i),
    .sync_sel_i (sync_sel_i),
    .sync_i     (sync_i),
    .ctr_o      (ctr_o),
    .sync_o     (sync_o),
    .gate_a_o   (gate_a_o),
    .gate_b_o   (gate_b_o)
);

// File: tb/sim_psfb_pwm_channel.sv
// Self-checking bench for psfb_pwm_channel.
module sim_psfb_pwm_channel;
    localparam int CW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] period, cmp, phase;
    logic          phase_en, sync_sel, sync_in;
    logic [DW-1:0] red, fed;
    logic [CW-1:0] ctr;
    logic          sync_out, ga, gb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Duty table: period, compare, rising delay A, rising delay B
    localparam int NV = 5;
    localparam int TBL [NV][4] = '{
        '{39, 20,  0,  0},
        '{39, 20, 20, 20},
        '{99, 50,  5, 12},
        '{19,  7,  3,  2},
        '{63, 10,  4, 30}
    };

    always #4 clk = ~clk;

    psfb_pwm_channel #(.CW(CW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .period_i(period), .cmp_i(cmp),
        .phase_i(phase), .phase_en_i(phase_en), .sync_sel_i(sync_sel),
        .sync_i(sync_in), .red_i(red), .fed_i(fed), .ctr_o(ctr),
        .sync_o(sync_out), .gate_a_o(ga), .gate_b_o(gb)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int c;
        int a_hi, b_hi, n_sync, n_ovl, bad_zero;
        rst_n = 1'b0; period = 5; cmp = 3; phase = 0;
        phase_en = 1'b0; sync_sel = 1'b0; sync_in = 1'b0;
        red = 0; fed = 0;
        @(negedge clk);
        repeat (3) tick();
        // R1: reset state
        chk(ctr == 0, "R1 ctr", ctr, 0);
        chk(!ga && !gb, "R1 gates", {ga, gb}, 0);
        chk(!sync_out, "R1 sync", sync_out, 0);

        // R2: count sequence 0..5 then wrap
        rst_n = 1'b1;
        for (int i = 0; i < 13; i++) begin
            tick();
            chk(ctr == CW'((i + 1) % 6), "R2 count", ctr, (i + 1) % 6);
        end

        // R4/R5/R6/R7: table-driven duty, dead band and sync pulse
        for (int v = 0; v < NV; v++) begin
            period = CW'(TBL[v][0]); cmp = CW'(TBL[v][1]);
            red = DW'(TBL[v][2]);    fed = DW'(TBL[v][3]);
            repeat (2 * (TBL[v][0] + 1) + 40) tick();
            a_hi = 0; b_hi = 0; n_sync = 0; n_ovl = 0; bad_zero = 0;
            for (int k = 0; k <= TBL[v][0]; k++) begin
                tick();
                a_hi += int'(ga);
                b_hi += int'(gb);
                n_sync += int'(sync_out);
                if (ga && gb) n_ovl++;
                if (sync_out && ctr != 0) bad_zero++;
            end
            if (TBL[v][2] == 0)
                chk(a_hi == TBL[v][1], "R4 duty", a_hi, TBL[v][1]);
            chk(a_hi == TBL[v][1] - TBL[v][2], "R5 gate A high", a_hi, TBL[v][1] - TBL[v][2]);
            chk(b_hi == TBL[v][0] + 1 - TBL[v][1] - TBL[v][3], "R5 gate B high",
                b_hi, TBL[v][0] + 1 - TBL[v][1] - TBL[v][3]);
            chk(n_ovl == 0, "R6 overlap", n_ovl, 0);
            chk(n_sync == 1, "R7 pulses per period", n_sync, 1);
            chk(bad_zero == 0, "R7 pulse on zero", bad_zero, 0);
        end

        // R3: immediate period write below the current count
        period = 200;
        while (ctr != 50) tick();
        period = 10;
        tick();
        chk(ctr == 0, "R3 immediate period", ctr, 0);

        // R8: sync loads the phase in slave mode
        period = 100;
        repeat (5) tick();
        phase_en = 1'b1; phase = 37; sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk(ctr == 37, "R8 phase load", ctr, 37);

        // R9: load beats a coincident wrap, no zero pulse
        while (ctr != 100) tick();
        phase = 5; sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk(ctr == 5, "R9 load priority", ctr, 5);
        chk(!sync_out, "R9 no wrap pulse", sync_out, 0);

        // R10: sync ignored when phase loading is off
        phase_en = 1'b0;
        repeat (3) tick();
        c = int'(ctr);
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk(ctr == CW'(c + 1), "R10 sync ignored", ctr, c + 1);

        // R11: pass-through relays sync_i and suppresses own wraps
        sync_sel = 1'b1; period = 9;
        repeat (3) tick();
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
        chk(sync_out, "R11 relay high", sync_out, 1);
        tick();
        chk(!sync_out, "R11 relay one cycle", sync_out, 0);
        n_sync = 0;
        for (int k = 0; k < 30; k++) begin
            tick();
            n_sync += int'(sync_out);
        end
        chk(n_sync == 0, "R11 own wraps suppressed", n_sync, 0);

        // R1: mid-run reset
        sync_sel = 1'b0;
        repeat (4) tick();
        rst_n = 1'b0;
        tick();
        chk(ctr == 0 && !ga && !gb && !sync_out, "R1 mid-run reset",
            {ctr, ga, gb, sync_out}, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule